// File: doc/BRIEF.md
# DSP Status Register Update Unit

This block holds the status fields of a fixed-point DSP core and applies their update rules each clock. The fields are a 3-bit auxiliary register pointer with a 3-bit save buffer, a 9-bit data page pointer, a carry flag, a sticky overflow flag, an interrupt mask bit and a memory-configuration bit. The core's decoder drives one-cycle strobes: load the whole status word, load the pointer, load the page, set or clear single bits, report add, subtract or shift carry results, report ALU overflow, report a taken overflow-conditional branch, and report a trap.

Every field is a register and changes on the clock edge after its strobe. The direct-addressing data address is built from the current page register and a 7-bit offset taken from the instruction word, with the page in the upper bits and the offset in the lower bits. When several sources hit one field in the same cycle, reset wins first, then a status-word load, then an explicit set or clear, then the arithmetic or event update.

Top module: `dsp_status_regs`

## Requirements
- R1: While `rst` is high at a clock edge, `carry` becomes 1, `int_mask` becomes 1, and `aux_ptr`, `aux_ptr_buf`, `page_ptr`, `ovf` and `cfg_prog` become 0.
- R2: A pointer load (`ptr_load`=1, `sw_load`=0) writes `ptr_val` to `aux_ptr` and the previous `aux_ptr` to `aux_ptr_buf`; otherwise both hold unless R3 applies.
- R3: A status-word load (`sw_load`=1) writes `sw_ptr` to both `aux_ptr_buf` and `aux_ptr`, and `sw_page`, `sw_carry`, `sw_ovf`, `sw_cfg` to their fields, overriding every other strobe on those fields.
- R4: `page_ptr` changes only on `page_load` (to `page_val`) or a status-word load; `dir_addr` equals `{page_ptr, instr_ofs}` with the page in bits 15:7 and the offset in bits 6:0.
- R5: Without shift16, an add sets `carry` to `alu_cy` (carry-out) and a subtract sets `carry` to the inverse of `alu_cy` (borrow).
- R6: With `shift16`=1, an add can only set `carry` (sets it when `alu_cy`=1) and a subtract can only clear it (clears it when `alu_cy`=1); otherwise `carry` holds.
- R7: A single-bit shift or rotate (`shift_en`) writes `shift_cy` to `carry`; among arithmetic strobes, add beats subtract, which beats shift.
- R8: `c_set` forces `carry` to 1 and `c_clr` forces it to 0, taking precedence over arithmetic updates; `c_set` wins if both are high.
- R9: `ovf` is set by `alu_ovf` and then stays set until reset, a status-word load or `ovbr_taken`; `alu_ovf` wins over `ovbr_taken` in the same cycle.
- R10: `int_mask` is set by `im_set`, cleared by `im_clr` (set wins if both), set by a hardware trap (`trap_taken`=1, `trap_is_sw`=0) when neither strobe is high, and left unchanged by a software trap and by a status-word load.
- R11: `cfg_prog` changes only on `cfg_set` (to 1), `cfg_clr` (to 0, `cfg_set` wins if both) or a status-word load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sw_load | input | 1 | Load the whole status word |
| sw_ptr | input | 3 | Status word pointer-buffer value (copied to the pointer too) |
| sw_page | input | 9 | Status word page value |
| sw_carry | input | 1 | Status word carry value |
| sw_ovf | input | 1 | Status word overflow value |
| sw_cfg | input | 1 | Status word memory-configuration value |
| ptr_load | input | 1 | Load the auxiliary register pointer |
| ptr_val | input | 3 | New pointer value |
| page_load | input | 1 | Load the data page pointer |
| page_val | input | 9 | New page value |
| c_set | input | 1 | Set carry |
| c_clr | input | 1 | Clear carry |
| cfg_set | input | 1 | Set memory-configuration bit |
| cfg_clr | input | 1 | Clear memory-configuration bit |
| im_set | input | 1 | Set interrupt mask |
| im_clr | input | 1 | Clear interrupt mask |
| add_en | input | 1 | Add result this cycle |
| sub_en | input | 1 | Subtract result this cycle |
| shift16 | input | 1 | The add or subtract used a 16-bit shift |
| alu_cy | input | 1 | Carry-out for add, borrow for subtract |
| shift_en | input | 1 | Single-bit shift or rotate result this cycle |
| shift_cy | input | 1 | Bit shifted out |
| alu_ovf | input | 1 | ALU overflow this cycle |
| ovbr_taken | input | 1 | Overflow-conditional branch taken |
| trap_taken | input | 1 | Trap taken this cycle |
| trap_is_sw | input | 1 | The trap came from software |
| instr_ofs | input | 7 | Low 7 bits of the instruction word |
| aux_ptr | output | 3 | Auxiliary register pointer |
| aux_ptr_buf | output | 3 | Pointer save buffer |
| page_ptr | output | 9 | Data page pointer |
| carry | output | 1 | Carry flag |
| ovf | output | 1 | Sticky overflow flag |
| int_mask | output | 1 | Maskable interrupt disable |
| cfg_prog | output | 1 | Memory-configuration bit |
| dir_addr | output | 16 | Direct-addressing data address |

## Verification
The bench aims at the shifted carry rules, where a design treating a shifted add like a plain add would clear a set carry when no carry-out occurs, and a plain-subtract treatment would set carry after a shifted subtract without borrow. It drives a status-word load together with a pointer load to catch a design that saves the old pointer into the buffer instead of copying the loaded value into both, and with trap and mask strobes to catch one that lets the word load touch the interrupt mask. Overflow is held across many quiet cycles and raised alongside a taken branch, exposing a non-sticky flag or the wrong same-cycle winner, and software traps are mixed in to show a mask that wrongly rises on them.

// File: rtl/dsp_status_regs.sv
module dsp_status_regs #(
  parameter int PTR_W  = 3,
  parameter int PAGE_W = 9,
  parameter int OFS_W  = 7,
  localparam int ADDR_W = PAGE_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_load,
  input  logic [PTR_W-1:0]  sw_ptr,
  input  logic [PAGE_W-1:0] sw_page,
  input  logic              sw_carry,
  input  logic              sw_ovf,
  input  logic              sw_cfg,
  input  logic              ptr_load,
  input  logic [PTR_W-1:0]  ptr_val,
  input  logic              page_load,
  input  logic [PAGE_W-1:0] page_val,
  input  logic              c_set,
  input  logic              c_clr,
  input  logic              cfg_set,
  input  logic              cfg_clr,
  input  logic              im_set,
  input  logic              im_clr,
  input  logic              add_en,
  input  logic              sub_en,
  input  logic              shift16,
  input  logic              alu_cy,
  input  logic              shift_en,
  input  logic              shift_cy,
  input  logic              alu_ovf,
  input  logic              ovbr_taken,
  input  logic              trap_taken,
  input  logic              trap_is_sw,
  input  logic [OFS_W-1:0]  instr_ofs,
  output logic [PTR_W-1:0]  aux_ptr,
  output logic [PTR_W-1:0]  aux_ptr_buf,
  output logic [PAGE_W-1:0] page_ptr,
  output logic              carry,
  output logic              ovf,
  output logic              int_mask,
  output logic              cfg_prog,
  output logic [ADDR_W-1:0] dir_addr
);

  logic c_arith;
  logic hw_trap;

  assign hw_trap  = trap_taken & ~trap_is_sw;
  assign dir_addr = {page_ptr, instr_ofs};

  always_comb begin
    c_arith = carry;
    if (add_en)
      c_arith = shift16 ? (carry | alu_cy) : alu_cy;
    else if (sub_en)
      c_arith = shift16 ? (carry & ~alu_cy) : ~alu_cy;
    else if (shift_en)
      c_arith = shift_cy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      aux_ptr     <= '0;
      aux_ptr_buf <= '0;
      page_ptr    <= '0;
      carry       <= 1'b1;
      ovf         <= 1'b0;
      int_mask    <= 1'b1;
      cfg_prog    <= 1'b0;
    end else begin
      if (sw_load) begin
        aux_ptr     <= sw_ptr;
        aux_ptr_buf <= sw_ptr;
      end else if (ptr_load) begin
        aux_ptr     <= ptr_val;
        aux_ptr_buf <= aux_ptr;
      end

      if (sw_load)        page_ptr <= sw_page;
      else if (page_load) page_ptr <= page_val;

      if (sw_load)    carry <= sw_carry;
      else if (c_set) carry <= 1'b1;
      else if (c_clr) carry <= 1'b0;
      else            carry <= c_arith;

      if (sw_load)         ovf <= sw_ovf;
      else if (alu_ovf)    ovf <= 1'b1;
      else if (ovbr_taken) ovf <= 1'b0;

      if (sw_load)      cfg_prog <= sw_cfg;
      else if (cfg_set) cfg_prog <= 1'b1;
      else if (cfg_clr) cfg_prog <= 1'b0;

      if (im_set)       int_mask <= 1'b1;
      else if (im_clr)  int_mask <= 1'b0;
      else if (hw_trap) int_mask <= 1'b1;
    end
  end

endmodule

// File: rtl/dsp_status_regs_chk.sv
module dsp_status_regs_chk #(
  parameter int PTR_W  = 3,
  parameter int PAGE_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              sw_load,
  input logic [PTR_W-1:0]  ptr_val,
  input logic              ptr_load,
  input logic              page_load,
  input logic              c_set,
  input logic              c_clr,
  input logic              add_en,
  input logic              shift16,
  input logic              alu_ovf,
  input logic              im_set,
  input logic              im_clr,
  input logic              trap_taken,
  input logic              trap_is_sw,
  input logic [PTR_W-1:0]  aux_ptr,
  input logic [PTR_W-1:0]  aux_ptr_buf,
  input logic [PAGE_W-1:0] page_ptr,
  input logic              carry,
  input logic              ovf,
  input logic              int_mask,
  input logic              cfg_prog
);

  assert_reset_vals_R1: assert property (@(posedge clk)
    rst |=> (carry && int_mask && !ovf && !cfg_prog && aux_ptr == '0 && aux_ptr_buf == '0 && page_ptr == '0));

  assert_ptr_save_R2: assert property (@(posedge clk) disable iff (rst)
    (ptr_load && !sw_load) |=> (aux_ptr_buf == $past(aux_ptr) && aux_ptr == $past(ptr_val)));

  assert_word_copy_R3: assert property (@(posedge clk) disable iff (rst)
    sw_load |=> (aux_ptr == aux_ptr_buf));

  assert_mask_kept_R10: assert property (@(posedge clk) disable iff (rst)
    (sw_load && !im_set && !im_clr && !trap_taken) |=> $stable(int_mask));

  assert_page_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!sw_load && !page_load) |=> $stable(page_ptr));

  assert_add16_no_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (add_en && shift16 && carry && !sw_load && !c_clr) |=> carry);

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    (alu_ovf && !sw_load) |=> ovf);

  assert_hw_trap_R10: assert property (@(posedge clk) disable iff (rst)
    (trap_taken && !trap_is_sw && !im_clr) |=> int_mask);

  assert_carry_set_R8: assert property (@(posedge clk) disable iff (rst)
    (c_set && !sw_load) |=> carry);

endmodule

bind dsp_status_regs dsp_status_regs_chk #(.PTR_W(PTR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst(rst), .sw_load(sw_load), .ptr_val(ptr_val), .ptr_load(ptr_load),
  .page_load(page_load), .c_set(c_set), .c_clr(c_clr), .add_en(add_en),
  .shift16(shift16), .alu_ovf(alu_ovf), .im_set(im_set), .im_clr(im_clr),
  .trap_taken(trap_taken), .trap_is_sw(trap_is_sw), .aux_ptr(aux_ptr),
  .aux_ptr_buf(aux_ptr_buf), .page_ptr(page_ptr), .carry(carry), .ovf(ovf),
  .int_mask(int_mask), .cfg_prog(cfg_prog)
);

// File: tb/dsp_status_regs_tb.sv
module dsp_status_regs_tb;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst = 1'b1;
  logic       sw_load = 0, ptr_load = 0, page_load = 0;
  logic [2:0] sw_ptr = 0, ptr_val = 0;
  logic [8:0] sw_page = 0, page_val = 0;
  logic       sw_carry = 0, sw_ovf = 0, sw_cfg = 0;
  logic       c_set = 0, c_clr = 0, cfg_set = 0, cfg_clr = 0, im_set = 0, im_clr = 0;
  logic       add_en = 0, sub_en = 0, shift16 = 0, alu_cy = 0, shift_en = 0, shift_cy = 0;
  logic       alu_ovf = 0, ovbr_taken = 0, trap_taken = 0, trap_is_sw = 0;
  logic [6:0] instr_ofs = 0;

  logic [2:0]  aux_ptr, aux_ptr_buf;
  logic [8:0]  page_ptr;
  logic        carry, ovf, int_mask, cfg_prog;
  logic [15:0] dir_addr;

  dsp_status_regs u_dut (
    .clk(clk), .rst(rst), .sw_load(sw_load), .sw_ptr(sw_ptr), .sw_page(sw_page),
    .sw_carry(sw_carry), .sw_ovf(sw_ovf), .sw_cfg(sw_cfg), .ptr_load(ptr_load),
    .ptr_val(ptr_val), .page_load(page_load), .page_val(page_val), .c_set(c_set),
    .c_clr(c_clr), .cfg_set(cfg_set), .cfg_clr(cfg_clr), .im_set(im_set), .im_clr(im_clr),
    .add_en(add_en), .sub_en(sub_en), .shift16(shift16), .alu_cy(alu_cy),
    .shift_en(shift_en), .shift_cy(shift_cy), .alu_ovf(alu_ovf), .ovbr_taken(ovbr_taken),
    .trap_taken(trap_taken), .trap_is_sw(trap_is_sw), .instr_ofs(instr_ofs),
    .aux_ptr(aux_ptr), .aux_ptr_buf(aux_ptr_buf), .page_ptr(page_ptr), .carry(carry),
    .ovf(ovf), .int_mask(int_mask), .cfg_prog(cfg_prog), .dir_addr(dir_addr)
  );

  int n_chk = 0, n_fail = 0;
  int m_ptr = 0, m_buf = 0, m_page = 0, m_c = 1, m_ov = 0, m_im = 1, m_cfg = 0;

  task automatic chk(string what, string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    int old_ptr;
    old_ptr = m_ptr;
    if (rst) begin
      m_ptr = 0; m_buf = 0; m_page = 0; m_c = 1; m_ov = 0; m_im = 1; m_cfg = 0;
      return;
    end
    if (sw_load) begin m_ptr = sw_ptr; m_buf = sw_ptr; end
    else if (ptr_load) begin m_ptr = ptr_val; m_buf = old_ptr; end
    if (sw_load) m_page = sw_page; else if (page_load) m_page = page_val;
    if (sw_load) m_c = sw_carry;
    else if (c_set) m_c = 1;
    else if (c_clr) m_c = 0;
    else if (add_en) begin
      if (!shift16) m_c = alu_cy; else if (alu_cy) m_c = 1;
    end else if (sub_en) begin
      if (!shift16) m_c = !alu_cy; else if (alu_cy) m_c = 0;
    end else if (shift_en) m_c = shift_cy;
    if (sw_load) m_ov = sw_ovf; else if (alu_ovf) m_ov = 1; else if (ovbr_taken) m_ov = 0;
    if (sw_load) m_cfg = sw_cfg; else if (cfg_set) m_cfg = 1; else if (cfg_clr) m_cfg = 0;
    if (im_set) m_im = 1; else if (im_clr) m_im = 0;
    else if (trap_taken && !trap_is_sw) m_im = 1;
  endtask

  task automatic compare_all();
    chk("aux_ptr", "R2", aux_ptr, m_ptr);
    chk("aux_ptr_buf", "R3", aux_ptr_buf, m_buf);
    chk("page_ptr", "R4", page_ptr, m_page);
    chk("dir_addr", "R4", dir_addr, m_page * 128 + instr_ofs);
    chk("carry", "R5", carry, m_c);
    chk("ovf", "R9", ovf, m_ov);
    chk("int_mask", "R10", int_mask, m_im);
    chk("cfg_prog", "R11", cfg_prog, m_cfg);
  endtask

  task automatic quiet();
    sw_load = 0; ptr_load = 0; page_load = 0; c_set = 0; c_clr = 0; cfg_set = 0;
    cfg_clr = 0; im_set = 0; im_clr = 0; add_en = 0; sub_en = 0; shift16 = 0;
    alu_cy = 0; shift_en = 0; shift_cy = 0; alu_ovf = 0; ovbr_taken = 0;
    trap_taken = 0; trap_is_sw = 0;
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    quiet();
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1;
    cyc(); cyc();
    // R1: literal reset state
    chk("reset carry", "R1", carry, 1);
    chk("reset int_mask", "R1", int_mask, 1);
    chk("reset ovf", "R1", ovf, 0);
    chk("reset cfg_prog", "R1", cfg_prog, 0);
    chk("reset ptr", "R1", aux_ptr, 0);
    rst = 0;
    cyc();

    // R2: pointer loads save old value
    ptr_load = 1; ptr_val = 3'd5; cyc();
    ptr_load = 1; ptr_val = 3'd2; cyc();
    chk("buf after two loads", "R2", aux_ptr_buf, 5);

    // R3: word load beats pointer load, copies to both, mask untouched
    im_clr = 1; cyc();
    sw_load = 1; sw_ptr = 3'd6; ptr_load = 1; ptr_val = 3'd1; sw_page = 9'h1A5;
    sw_carry = 0; sw_ovf = 1; sw_cfg = 1; page_load = 1; page_val = 9'h003; c_set = 1;
    cyc();
    chk("word ptr", "R3", aux_ptr, 6);
    chk("word buf", "R3", aux_ptr_buf, 6);
    chk("word leaves mask", "R10", int_mask, 0);
    chk("word carry over set", "R8", carry, 0);

    // R4: page load and address
    page_load = 1; page_val = 9'h0F0; instr_ofs = 7'h55; cyc();
    instr_ofs = 7'h55;
    chk("dir_addr", "R4", dir_addr, 16'h7855);

    // R5 / R6: carry rules
    add_en = 1; alu_cy = 1; cyc();
    add_en = 1; shift16 = 1; alu_cy = 0; cyc();
    chk("add16 keeps carry", "R6", carry, 1);
    sub_en = 1; shift16 = 1; alu_cy = 0; cyc();
    chk("sub16 no borrow keeps", "R6", carry, 1);
    sub_en = 1; alu_cy = 1; cyc();
    chk("sub borrow clears", "R5", carry, 0);
    sub_en = 1; shift16 = 1; alu_cy = 0; cyc();
    chk("sub16 cannot set", "R6", carry, 0);
    add_en = 1; shift16 = 1; alu_cy = 1; cyc();
    sub_en = 1; shift16 = 1; alu_cy = 1; cyc();
    chk("sub16 borrow clears", "R6", carry, 0);

    // R7: shift writes carry; add beats shift
    shift_en = 1; shift_cy = 1; cyc();
    add_en = 1; alu_cy = 0; shift_en = 1; shift_cy = 1; cyc();
    chk("add over shift", "R7", carry, 0);

    // R8: set/clear beat arithmetic
    c_set = 1; c_clr = 1; sub_en = 1; alu_cy = 1; cyc();
    chk("set wins", "R8", carry, 1);

    // R9: sticky overflow
    alu_ovf = 1; ovbr_taken = 1; cyc();
    for (int i = 0; i < 5; i++) cyc();
    chk("ovf sticky", "R9", ovf, 1);
    ovbr_taken = 1; cyc();
    chk("ovf cleared by branch", "R9", ovf, 0);

    // R10: traps
    im_clr = 1; cyc();
    trap_taken = 1; trap_is_sw = 1; cyc();
    chk("sw trap no effect", "R10", int_mask, 0);
    trap_taken = 1; trap_is_sw = 0; cyc();
    chk("hw trap sets", "R10", int_mask, 1);

    // R11: configuration bit
    cfg_clr = 1; cyc();
    cfg_set = 1; cfg_clr = 1; cyc();
    chk("cfg set wins", "R11", cfg_prog, 1);

    // random mix against the model, all requirements
    for (int i = 0; i < 4000; i++) begin
      sw_load = ($urandom_range(0, 15) == 0);
      sw_ptr = 3'($urandom); sw_page = 9'($urandom);
      sw_carry = 1'($urandom); sw_ovf = 1'($urandom); sw_cfg = 1'($urandom);
      ptr_load = ($urandom_range(0, 3) == 0); ptr_val = 3'($urandom);
      page_load = ($urandom_range(0, 5) == 0); page_val = 9'($urandom);
      c_set = ($urandom_range(0, 9) == 0); c_clr = ($urandom_range(0, 9) == 0);
      cfg_set = ($urandom_range(0, 9) == 0); cfg_clr = ($urandom_range(0, 9) == 0);
      im_set = ($urandom_range(0, 9) == 0); im_clr = ($urandom_range(0, 7) == 0);
      add_en = ($urandom_range(0, 3) == 0); sub_en = ($urandom_range(0, 3) == 0);
      shift16 = 1'($urandom); alu_cy = 1'($urandom);
      shift_en = ($urandom_range(0, 3) == 0); shift_cy = 1'($urandom);
      alu_ovf = ($urandom_range(0, 11) == 0); ovbr_taken = ($urandom_range(0, 7) == 0);
      trap_taken = ($urandom_range(0, 7) == 0); trap_is_sw = 1'($urandom);
      instr_ofs = 7'($urandom);
      rst = ($urandom_range(0, 499) == 0);
      cyc();
      rst = 0;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule